// File: doc/BRIEF.md
# Master-Mode Audio Clock Divider

This block turns one external master clock into the timing an audio ADC core needs. A prescaler divides the master clock by 1, 2, 3 or 4 and emits an internal tick, an enable pulse rather than a new clock. Three dividers count those ticks. The first makes the bit clock. The second makes the frame clock, at sixteen ticks per unit of its divider byte. The third makes an ADC clock enable. All logic runs on the master clock, so the whole block is one clock domain.

When master mode is selected, the block drives its own frame clock and bit clock and raises both output enables. When slave mode is selected, the enables drop and the two clock outputs carry the externally supplied frame and bit clocks unchanged. The bit and frame dividers are held at zero while the block is a slave. On entry to master mode every divider, including the prescaler, starts from zero in the same cycle, so the first edges of the frame clock and the bit clock have a known position.

Top module: `audclk_master_div`

## Requirements
- R1: Prescaler code c (0..3) gives a one-cycle `imclk_en_o` pulse every P = c+1 master clock cycles: code 0 divides by 1, 1 by 2, 2 by 3 and 3 by 4.
- R2: In master mode `sclk_o` has a period of P·N master cycles, where N is `bit_div_i`, with values 0 and 1 treated as 2. It is low for P·floor(N/2) cycles and high for the rest.
- R3: In master mode `lrck_o` has a period of P·F master cycles, where F = 16·`frame_div_i`, with 0 treated as 1. Duty is exactly 50 %. A byte of 16 gives a ratio of 256 and a byte of 24 gives 384.
- R4: `adc_en_o` is a one-cycle pulse every P·A master cycles, where A is `adc_div_i`, with 0 treated as 1. It is only ever high together with `imclk_en_o`.
- R5: When `master_i` is 1 (registered on one clock edge), `lrck_oe_o` and `sclk_oe_o` are 1. When it is 0, both are 0 and `lrck_o`/`sclk_o` equal `ext_lrck_i`/`ext_sclk_i` combinationally.
- R6: On the first edge that samples `master_i` = 1, all dividers restart. After that edge `lrck_o` and `sclk_o` are both low. `sclk_o` first rises P·floor(N/2) edges later and `lrck_o` first rises P·F/2 edges later.
- R7: While `rst_ni` is low, the block is in slave mode: both output enables are 0 and the clock outputs follow the external clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | External master clock, the only clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = generate clocks (master), 0 = pass external clocks (slave) |
| presc_code_i | input | PRE_W (2) | Prescaler code, divisor = code+1 |
| frame_div_i | input | FDIV_W (8) | Frame divider byte, ratio = byte·16 ticks |
| bit_div_i | input | BDIV_W (6) | Bit-clock divider in ticks |
| adc_div_i | input | ADIV_W (4) | ADC enable divider in ticks |
| ext_lrck_i | input | 1 | External frame clock used in slave mode |
| ext_sclk_i | input | 1 | External bit clock used in slave mode |
| imclk_en_o | output | 1 | Internal master clock tick (enable) |
| adc_en_o | output | 1 | ADC clock enable pulse |
| lrck_o | output | 1 | Frame clock out |
| sclk_o | output | 1 | Bit clock out |
| lrck_oe_o | output | 1 | Output enable for the frame clock pin |
| sclk_oe_o | output | 1 | Output enable for the bit clock pin |

## Verification
Call the edge that first samples master mode edge k. Every clock output is a register updated at a tick edge, and the first rises are due P·floor(N/2) and P·F/2 edges after edge k. The bench counts rising edges from the one that applies the mode change and samples every output half a period after each edge. Periods and high times are counted in whole negative-edge samples between two rising samples. Pulse spacing is counted between two high samples. The slave path is combinational, so it is checked shortly after the external clocks change.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Role of the block on the shared audio clock pins
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // Registered top-level control state
    typedef struct packed {
        role_e role;
    } ctrl_t;

endpackage

// File: rtl/audclk_pulse.sv
// Enable-pulse divider: emits one pulse every (last_i+1) advances.
module audclk_pulse #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] last_i,
    output logic         pulse_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;
    logic      at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt >= last_i);
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv_i) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
        pulse_o = adv_i && !clr_i && at_end;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/audclk_phase.sv
// Square-wave divider: period (last_i+1) advances, low while count < half_i.
module audclk_phase #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] last_i,
    input  logic [W-1:0] half_i,
    output logic         phase_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         hi;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv_i) begin
            st_d.cnt = (st_q.cnt >= last_i) ? '0 : st_q.cnt + 1'b1;
        end
        // Output level is registered alongside the count it decodes
        st_d.hi = (st_d.cnt >= half_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o = st_q.hi;

endmodule

// File: rtl/audclk_master_div.sv
module audclk_master_div
    import audclk_pkg::*;
#(
    parameter int PRE_W       = 2,
    parameter int FDIV_W      = 8,
    parameter int BDIV_W      = 6,
    parameter int ADIV_W      = 4,
    parameter int FRAME_SHIFT = 4
) (
    input  logic              mclk_i,
    input  logic              rst_ni,
    input  logic              master_i,
    input  logic [PRE_W-1:0]  presc_code_i,
    input  logic [FDIV_W-1:0] frame_div_i,
    input  logic [BDIV_W-1:0] bit_div_i,
    input  logic [ADIV_W-1:0] adc_div_i,
    input  logic              ext_lrck_i,
    input  logic              ext_sclk_i,
    output logic              imclk_en_o,
    output logic              adc_en_o,
    output logic              lrck_o,
    output logic              sclk_o,
    output logic              lrck_oe_o,
    output logic              sclk_oe_o
);

    localparam int FRAME_W = FDIV_W + FRAME_SHIFT;
    localparam logic [BDIV_W-1:0] BIT_MIN = BDIV_W'(2);

    ctrl_t ctrl_d, ctrl_q;

    logic                restart;
    logic                hold;
    logic                tick;
    logic [BDIV_W-1:0]   bit_n, bit_last, bit_half;
    logic [FDIV_W-1:0]   frame_sel;
    logic [FRAME_W-1:0]  frame_f, frame_last, frame_half;
    logic [ADIV_W-1:0]   adc_last;
    logic                bit_ph, frame_ph;

    // Mode register and divider limits
    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.role = master_i ? ROLE_MASTER : ROLE_SLAVE;

        restart = master_i && (ctrl_q.role == ROLE_SLAVE);
        hold    = (ctrl_q.role == ROLE_SLAVE);

        bit_n    = (bit_div_i < BIT_MIN) ? BIT_MIN : bit_div_i;
        bit_last = bit_n - 1'b1;
        bit_half = bit_n >> 1;

        frame_sel  = (frame_div_i == '0) ? FDIV_W'(1) : frame_div_i;
        frame_f    = {frame_sel, {FRAME_SHIFT{1'b0}}};
        frame_last = frame_f - 1'b1;
        frame_half = frame_f >> 1;

        adc_last = (adc_div_i == '0) ? '0 : adc_div_i - 1'b1;
    end

    always_ff @(posedge mclk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '{role: ROLE_SLAVE};
        else         ctrl_q <= ctrl_d;
    end

    // Prescaler: tick every presc_code_i+1 master clocks
    audclk_pulse #(.W(PRE_W)) u_presc (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .clr_i   (restart),
        .adv_i   (1'b1),
        .last_i  (presc_code_i),
        .pulse_o (tick)
    );

    // ADC enable divider, counted in ticks
    audclk_pulse #(.W(ADIV_W)) u_adc (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .clr_i   (restart),
        .adv_i   (tick),
        .last_i  (adc_last),
        .pulse_o (adc_en_o)
    );

    // Bit clock
    audclk_phase #(.W(BDIV_W)) u_bit (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .clr_i   (hold),
        .adv_i   (tick),
        .last_i  (bit_last),
        .half_i  (bit_half),
        .phase_o (bit_ph)
    );

    // Frame clock
    audclk_phase #(.W(FRAME_W)) u_frame (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .clr_i   (hold),
        .adv_i   (tick),
        .last_i  (frame_last),
        .half_i  (frame_half),
        .phase_o (frame_ph)
    );

    // Pin side
    always_comb begin
        imclk_en_o = tick;
        lrck_oe_o  = (ctrl_q.role == ROLE_MASTER);
        sclk_oe_o  = (ctrl_q.role == ROLE_MASTER);
        lrck_o     = lrck_oe_o ? frame_ph : ext_lrck_i;
        sclk_o     = sclk_oe_o ? bit_ph   : ext_sclk_i;
    end

endmodule

// File: rtl/audclk_checker.sv
module audclk_checker #(
    parameter int PRE_W = 2
) (
    input logic             mclk_i,
    input logic             rst_ni,
    input logic [PRE_W-1:0] presc_code_i,
    input logic             ext_lrck_i,
    input logic             ext_sclk_i,
    input logic             imclk_en_o,
    input logic             adc_en_o,
    input logic             lrck_o,
    input logic             sclk_o,
    input logic             lrck_oe_o,
    input logic             sclk_oe_o
);

    // R1: after a tick a non-unity prescaler leaves at least one idle cycle
    assert_tick_gap_R1: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        (imclk_en_o && presc_code_i != '0) |=> (!imclk_en_o || presc_code_i == '0));

    // R2: generated bit clock moves only on edges that saw a tick
    assert_sclk_hold_R2: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        (sclk_oe_o && $past(sclk_oe_o) && !$past(imclk_en_o)) |-> $stable(sclk_o));

    // R3: generated frame clock moves only on edges that saw a tick
    assert_lrck_hold_R3: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        (lrck_oe_o && $past(lrck_oe_o) && !$past(imclk_en_o)) |-> $stable(lrck_o));

    // R4: ADC enable coincides with an internal tick
    assert_adc_on_tick_R4: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        adc_en_o |-> imclk_en_o);

    // R5: slave mode passes the external clocks
    assert_slave_pass_R5: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !lrck_oe_o |-> (lrck_o == ext_lrck_i && sclk_o == ext_sclk_i));

    // R6: master entry starts both clocks low
    assert_entry_low_R6: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $rose(lrck_oe_o) |-> (!lrck_o && !sclk_o));

endmodule

bind audclk_master_div audclk_checker #(.PRE_W(PRE_W)) i_chk (
    .mclk_i       (mclk_i),
    .rst_ni       (rst_ni),
    .presc_code_i (presc_code_i),
    .ext_lrck_i   (ext_lrck_i),
    .ext_sclk_i   (ext_sclk_i),
    .imclk_en_o   (imclk_en_o),
    .adc_en_o     (adc_en_o),
    .lrck_o       (lrck_o),
    .sclk_o       (sclk_o),
    .lrck_oe_o    (lrck_oe_o),
    .sclk_oe_o    (sclk_oe_o)
);

// File: tb/test_audclk_master_div.sv
module test_audclk_master_div;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;
    localparam int GUARD      = 20000;

    // {prescaler code[2], bit div[6], frame byte[8], adc div[4]}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 6'd4, 8'h10, 4'd2},
        {2'd2, 6'd6, 8'h01, 4'd3},
        {2'd1, 6'd0, 8'h02, 4'd0},
        {2'd3, 6'd3, 8'h01, 4'd5},
        {2'd0, 6'd1, 8'h18, 4'd15},
        {2'd2, 6'd8, 8'h00, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       master;
    logic [1:0] presc;
    logic [7:0] fdiv;
    logic [5:0] bdiv;
    logic [3:0] adiv;
    logic       ext_lrck, ext_sclk;
    logic       imclk_en, adc_en, lrck, sclk, lrck_oe, sclk_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audclk_master_div i_audclk_master_div (
        .mclk_i       (clk),
        .rst_ni       (rst_n),
        .master_i     (master),
        .presc_code_i (presc),
        .frame_div_i  (fdiv),
        .bit_div_i    (bdiv),
        .adc_div_i    (adiv),
        .ext_lrck_i   (ext_lrck),
        .ext_sclk_i   (ext_sclk),
        .imclk_en_o   (imclk_en),
        .adc_en_o     (adc_en),
        .lrck_o       (lrck),
        .sclk_o       (sclk),
        .lrck_oe_o    (lrck_oe),
        .sclk_oe_o    (sclk_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0:       return sclk;
            1:       return lrck;
            2:       return adc_en;
            default: return imclk_en;
        endcase
    endfunction

    // Period and high time of a clock, in negedge samples
    task automatic clk_period(input int sel, output int per, output int hi);
        logic prev, cur;
        int   g = 0;
        prev = pick(sel);
        while (g < GUARD) begin
            @(negedge clk); g++;
            cur = pick(sel);
            if (!prev && cur) break;
            prev = cur;
        end
        per = 0; hi = 0; prev = 1'b1;
        while (per < GUARD) begin
            @(negedge clk); per++;
            cur = pick(sel);
            if (cur) hi++;
            if (!prev && cur) break;
            prev = cur;
        end
    endtask

    // Spacing of a pulse, in negedge samples
    task automatic pulse_gap(input int sel, output int per);
        int g = 0;
        while (!pick(sel) && g < GUARD) begin @(negedge clk); g++; end
        per = 0;
        do begin @(negedge clk); per++; end while (!pick(sel) && per < GUARD);
    endtask

    // Leave master mode, re-enter, measure first rises (edge count from edge k)
    task automatic enter(output int lat_s, output int lat_l);
        int n = 0;
        master = 1'b0;
        repeat (3) @(negedge clk);
        master = 1'b1;
        lat_s = -1; lat_l = -1;
        while ((lat_s < 0 || lat_l < 0) && n < GUARD) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 1) begin
                check("R6 lrck low after entry", int'(lrck), 0);
                check("R6 sclk low after entry", int'(sclk), 0);
                check("R5 lrck_oe in master", int'(lrck_oe), 1);
                check("R5 sclk_oe in master", int'(sclk_oe), 1);
            end
            if (lat_s < 0 && sclk) lat_s = n;
            if (lat_l < 0 && lrck) lat_l = n;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; master = 1'b0;
        presc = 2'd0; fdiv = 8'h10; bdiv = 6'd4; adiv = 4'd2;
        ext_lrck = 1'b1; ext_sclk = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state is slave with passthrough
        check("R7 lrck_oe in reset", int'(lrck_oe), 0);
        check("R7 sclk_oe in reset", int'(sclk_oe), 0);
        check("R7 lrck passthrough in reset", int'(lrck), 1);
        check("R7 sclk passthrough in reset", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int p, nb, f, a, ls, ll, per, hi;
            {presc, bdiv, fdiv, adiv} = VEC[v];
            p  = int'(presc) + 1;
            nb = (bdiv < 6'd2) ? 2 : int'(bdiv);
            f  = 16 * ((fdiv == 8'h00) ? 1 : int'(fdiv));
            a  = (adiv == 4'd0) ? 1 : int'(adiv);

            enter(ls, ll);
            check($sformatf("R6 sclk first rise v%0d", v), ls, 1 + p * (nb / 2));
            check($sformatf("R6 lrck first rise v%0d", v), ll, 1 + p * (f / 2));

            clk_period(0, per, hi);
            check($sformatf("R2 sclk period v%0d", v), per, p * nb);
            check($sformatf("R2 sclk high v%0d", v), hi, p * (nb - nb / 2));

            clk_period(1, per, hi);
            check($sformatf("R3 lrck period v%0d", v), per, p * f);
            check($sformatf("R3 lrck high v%0d", v), hi, p * f / 2);

            pulse_gap(2, per);
            check($sformatf("R4 adc enable spacing v%0d", v), per, p * a);

            pulse_gap(3, per);
            check($sformatf("R1 tick spacing v%0d", v), per, p);
        end

        // R5: slave passthrough after leaving master mode
        master = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            ext_sclk = i[0];
            ext_lrck = i[1];
            #1;
            check("R5 lrck_oe in slave", int'(lrck_oe), 0);
            check("R5 sclk_oe in slave", int'(sclk_oe), 0);
            check("R5 lrck passthrough", int'(lrck), int'(i[1]));
            check("R5 sclk passthrough", int'(sclk), int'(i[0]));
            @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule